// File: doc/BRIEF.md
# Control Word Normalising Shim

This block keeps the small amount of floating-point control state that an execution model actually honours: a 2-bit rounding mode for a stack-style FPU, a 2-bit rounding mode for a vector unit, and four condition-code flags. Software loads full control words into it. The shim keeps only the rounding field of each word. Any other setting it cannot honour raises a sticky warning with a code; that setting is never applied.

Reads never echo the written word. Each control word is rebuilt from a fixed default with the stored rounding mode inserted, so only four values can come back from each register. The condition codes are loaded from a status-word image and read back at the same bit positions. All other bits of that image are zero.

Rounding-mode encoding for both units: 0 = to nearest, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero.

Top module: `ctrl_word_shim`

## Requirements
- R1: After reset, fpu_cw_o reads 0x037F, vec_csr_o reads 0x00001F80, cc_o reads 0x0000, warn_o is 0 and warn_code_o is 0.
- R2: A load through fpu_cw_we_i keeps only bits 11:10 of the written word as the FPU rounding mode. From the next cycle, fpu_cw_o reads 0x037F with that mode in bits 11:10 (0x037F, 0x077F, 0x0B7F or 0x0F7F).
- R3: A load through vec_csr_we_i keeps only bits 14:13 of the written word as the vector rounding mode. From the next cycle, vec_csr_o reads 0x1F80 with that mode in bits 14:13 (0x1F80, 0x3F80, 0x5F80 or 0x7F80). Bits 31:16 of the written word have no effect.
- R4: An FPU load with any of exception-mask bits 5:0 at zero raises warning code 1 (unmask). Otherwise, an FPU load whose precision field in bits 9:8 is not 2'b11 raises code 2 (precision). The rounding mode is updated even when a warning is raised.
- R5: A vector load with any of mask bits 12:7 at zero raises code 1. Otherwise, a vector load with flush-to-zero (bit 15) set raises code 2. Otherwise, a vector load with denormals-are-zero (bit 6) set raises code 3. The rounding mode is still updated.
- R6: warn_code_o holds the first nonzero code until warn_clr_i is pulsed. Warnings raised while a code is held are ignored. warn_o is 1 exactly when warn_code_o is nonzero.
- R7: If warn_clr_i and a warning-raising load fall in the same cycle, the new code is captured. If both units raise a warning in the same cycle, the lower nonzero code is captured.
- R8: A load through cc_we_i takes bits 14, 10, 9 and 8 (C3, C2, C1, C0) of cc_wdata_i. From the next cycle, cc_o shows them at the same positions with every other bit zero, i.e. cc_o equals the written word AND 0x4700.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fpu_cw_we_i | input | 1 | FPU control-word load strobe |
| fpu_cw_wdata_i | input | 16 | FPU control word to load |
| fpu_cw_o | output | 16 | Canonical FPU control word |
| vec_csr_we_i | input | 1 | Vector control/status load strobe |
| vec_csr_wdata_i | input | 32 | Vector control/status word to load |
| vec_csr_o | output | 32 | Canonical vector control/status word |
| cc_we_i | input | 1 | Condition-code load strobe |
| cc_wdata_i | input | 16 | Status-word image holding the condition codes |
| cc_o | output | 16 | Condition codes at status-word positions |
| warn_clr_i | input | 1 | Clears the held warning |
| warn_o | output | 1 | A warning is held |
| warn_code_o | output | 2 | Held warning code (0 none, 1 unmask, 2 precision/FZ, 3 DAZ) |

## Verification
Two collisions are provoked on purpose: a clear pulse in the same cycle as a warning-raising load, and FPU and vector loads that both warn in one cycle. In the first case the bench expects the new code and not zero. In the second it expects the lower of the two codes. A condition-code load is also issued alongside a control-word load, and the bench judges that each register takes only its own data.

// File: rtl/shim_pkg.sv
package shim_pkg;
  localparam int RM_W   = 2;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    WARN_NONE    = 2'd0,
    WARN_UNMASK  = 2'd1,
    WARN_PREC_FZ = 2'd2,
    WARN_DAZ     = 2'd3
  } warn_e;

  // lower nonzero code wins
  function automatic warn_e warn_pick(warn_e a, warn_e b);
    if (a == WARN_NONE) return b;
    if (b == WARN_NONE) return a;
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/cw_unit.sv
module cw_unit
  import shim_pkg::*;
#(
  parameter bit          IS_VEC    = 1'b0,
  parameter int          DW        = 16,
  parameter int          RM_LSB    = 10,
  parameter logic [31:0] DFLT_WORD = 32'h037F,
  parameter int          MASK_LSB  = 0,
  parameter int          MASK_W    = 6,
  parameter int          PC_LSB    = 8,
  parameter int          FZ_BIT    = 15,
  parameter int          DAZ_BIT   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_o,
  output warn_e         code_o
);
  localparam logic [DW-1:0] DFLT   = DW'(DFLT_WORD);
  localparam logic [DW-1:0] RM_MSK = DW'({RM_W{1'b1}}) << RM_LSB;

  logic [RM_W-1:0] rm_q;
  warn_e           scr_code;
  logic            unmask;

  assign unmask = ~&wdata_i[MASK_LSB +: MASK_W];

  generate
    if (IS_VEC) begin : g_vec
      always_comb begin
        if (unmask)                scr_code = WARN_UNMASK;
        else if (wdata_i[FZ_BIT])  scr_code = WARN_PREC_FZ;
        else if (wdata_i[DAZ_BIT]) scr_code = WARN_DAZ;
        else                       scr_code = WARN_NONE;
      end
    end else begin : g_fpu
      always_comb begin
        if (unmask)                             scr_code = WARN_UNMASK;
        else if (wdata_i[PC_LSB +: 2] != 2'b11) scr_code = WARN_PREC_FZ;
        else                                    scr_code = WARN_NONE;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rm_q <= '0;
    else if (we_i) rm_q <= wdata_i[RM_LSB +: RM_W];
  end

  assign rd_o   = DFLT | (DW'(rm_q) << RM_LSB);
  assign code_o = we_i ? scr_code : WARN_NONE;

  // R2 R3
  rd_canonical_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o & ~RM_MSK) == DFLT);
  // R2 R3
  rm_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rd_o[RM_LSB +: RM_W] == $past(wdata_i[RM_LSB +: RM_W]));
endmodule

// File: rtl/warn_latch.sv
module warn_latch
  import shim_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  warn_e code_a_i,
  input  warn_e code_b_i,
  output warn_e code_o
);
  warn_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               code_q <= WARN_NONE;
    else if (clr_i || code_q == WARN_NONE)     code_q <= warn_pick(code_a_i, code_b_i);
  end

  assign code_o = code_q;

  // R6
  warn_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != WARN_NONE && !clr_i) |=> code_q == $past(code_q));
  // R7
  clr_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && code_a_i == WARN_NONE && code_b_i == WARN_NONE) |=> code_q == WARN_NONE);
endmodule

// File: rtl/cc_pack.sv
module cc_pack #(
  parameter int SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] cc_o
);
  localparam logic [SW-1:0] CC_MSK = SW'(16'h4700);

  logic [3:0] cc_q; // {C3,C2,C1,C0}

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cc_q <= '0;
    else if (we_i) cc_q <= {wdata_i[14], wdata_i[10], wdata_i[9], wdata_i[8]};
  end

  always_comb begin
    cc_o     = '0;
    cc_o[14] = cc_q[3];
    cc_o[10] = cc_q[2];
    cc_o[9]  = cc_q[1];
    cc_o[8]  = cc_q[0];
  end

  // R8
  cc_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_o & ~CC_MSK) == '0);
  // R8
  cc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cc_o == ($past(wdata_i) & CC_MSK));
endmodule

// File: rtl/ctrl_word_shim.sv
module ctrl_word_shim
  import shim_pkg::*;
#(
  parameter int FPU_W = 16,
  parameter int VEC_W = 32,
  parameter int SW_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fpu_cw_we_i,
  input  logic [FPU_W-1:0] fpu_cw_wdata_i,
  output logic [FPU_W-1:0] fpu_cw_o,
  input  logic             vec_csr_we_i,
  input  logic [VEC_W-1:0] vec_csr_wdata_i,
  output logic [VEC_W-1:0] vec_csr_o,
  input  logic             cc_we_i,
  input  logic [SW_W-1:0]  cc_wdata_i,
  output logic [SW_W-1:0]  cc_o,
  input  logic             warn_clr_i,
  output logic             warn_o,
  output logic [1:0]       warn_code_o
);
  warn_e fpu_code, vec_code, held_code;

  cw_unit #(
    .IS_VEC(1'b0), .DW(FPU_W), .RM_LSB(10), .DFLT_WORD(32'h037F),
    .MASK_LSB(0), .MASK_W(6), .PC_LSB(8), .FZ_BIT(15), .DAZ_BIT(6)
  ) i_fpu (
    .clk_i, .rst_ni, .we_i(fpu_cw_we_i), .wdata_i(fpu_cw_wdata_i),
    .rd_o(fpu_cw_o), .code_o(fpu_code)
  );

  cw_unit #(
    .IS_VEC(1'b1), .DW(VEC_W), .RM_LSB(13), .DFLT_WORD(32'h1F80),
    .MASK_LSB(7), .MASK_W(6), .PC_LSB(8), .FZ_BIT(15), .DAZ_BIT(6)
  ) i_vec (
    .clk_i, .rst_ni, .we_i(vec_csr_we_i), .wdata_i(vec_csr_wdata_i),
    .rd_o(vec_csr_o), .code_o(vec_code)
  );

  warn_latch i_warn (
    .clk_i, .rst_ni, .clr_i(warn_clr_i),
    .code_a_i(fpu_code), .code_b_i(vec_code), .code_o(held_code)
  );

  cc_pack #(.SW(SW_W)) i_cc (
    .clk_i, .rst_ni, .we_i(cc_we_i), .wdata_i(cc_wdata_i), .cc_o(cc_o)
  );

  assign warn_code_o = held_code;
  assign warn_o      = (held_code != WARN_NONE);

  // R6
  warn_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o == (warn_code_o != 2'd0));
endmodule

// File: tb/test_ctrl_word_shim.sv
module test_ctrl_word_shim;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] fpu;
    logic [31:0] vec;
    logic [15:0] cc;
    logic [1:0]  code;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        fpu_we = 0, vec_we = 0, cc_we = 0, clr = 0;
  logic [15:0] fpu_wd = '0, cc_wd = '0;
  logic [31:0] vec_wd = '0;
  logic [15:0] fpu_rd, cc_rd;
  logic [31:0] vec_rd;
  logic        warn;
  logic [1:0]  code;

  int errors = 0, checks = 0;
  exp_t sb[$];
  logic [1:0]  m_rf = 0, m_rv = 0, m_code = 0;
  logic [15:0] m_cc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_word_shim i_ctrl_word_shim (
    .clk_i(clk), .rst_ni(rst_n),
    .fpu_cw_we_i(fpu_we), .fpu_cw_wdata_i(fpu_wd), .fpu_cw_o(fpu_rd),
    .vec_csr_we_i(vec_we), .vec_csr_wdata_i(vec_wd), .vec_csr_o(vec_rd),
    .cc_we_i(cc_we), .cc_wdata_i(cc_wd), .cc_o(cc_rd),
    .warn_clr_i(clr), .warn_o(warn), .warn_code_o(code)
  );

  function automatic logic [1:0] fpu_warn(logic [15:0] w);
    if (w[5:0] != 6'h3F) return 2'd1;
    if (w[9:8] != 2'b11) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [1:0] vec_warn(logic [31:0] w);
    if (w[12:7] != 6'h3F) return 2'd1;
    if (w[15]) return 2'd2;
    if (w[6])  return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [1:0] pick(logic [1:0] a, logic [1:0] b);
    if (a == 0) return b;
    if (b == 0) return a;
    return (a < b) ? a : b;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.fpu  = 16'h037F | (16'(m_rf) << 10);
    e.vec  = 32'h1F80 | (32'(m_rv) << 13);
    e.cc   = m_cc;
    e.code = m_code;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic op(input logic fw, input logic [15:0] fd, input logic vw,
                    input logic [31:0] vd, input logic cw, input logic [15:0] cd,
                    input logic cl, input string tag);
    logic [1:0] nc;
    @(negedge clk);
    fpu_we = fw; fpu_wd = fd; vec_we = vw; vec_wd = vd;
    cc_we = cw; cc_wd = cd; clr = cl;
    nc = pick(fw ? fpu_warn(fd) : 2'd0, vw ? vec_warn(vd) : 2'd0);
    if (fw) m_rf = fd[11:10];
    if (vw) m_rv = vd[14:13];
    if (cw) m_cc = cd & 16'h4700;
    if (cl || m_code == 0) m_code = nc;
    @(posedge clk);
    push(tag);
    @(negedge clk);
    fpu_we = 0; vec_we = 0; cc_we = 0; clr = 0;
    push({tag, " hold"});
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops at negedge, away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "fpu_cw", 32'(fpu_rd), 32'(e.fpu));
      cmp(e.tag, "vec_csr", vec_rd, e.vec);
      cmp(e.tag, "cc", 32'(cc_rd), 32'(e.cc));
      cmp(e.tag, "code", 32'(code), 32'(e.code));
      cmp(e.tag, "warn", 32'(warn), 32'(e.code != 0));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); push("R1 reset");
    // R2 plain loads
    op(1, 16'h037F, 0, 0, 0, 0, 0, "R2 rm0");
    op(1, 16'h0F7F, 0, 0, 0, 0, 0, "R2 rm3");
    op(1, 16'hF77F, 0, 0, 0, 0, 0, "R2 junk high");
    // R4 unmask keeps rounding update
    op(1, 16'h0B7E, 0, 0, 0, 0, 0, "R4 unmask");
    // R6 later precision warning ignored
    op(1, 16'h0C7F, 0, 0, 0, 0, 0, "R6 sticky");
    op(0, 0, 0, 0, 0, 0, 1, "R6 clear");
    op(1, 16'h007F, 0, 0, 0, 0, 0, "R4 precision");
    op(0, 0, 0, 0, 0, 0, 1, "R6 clear2");
    op(1, 16'h0040, 0, 0, 0, 0, 0, "R4 unmask over prec");
    // R7 clear + DAZ same cycle
    op(0, 0, 1, 32'h1FC0, 0, 0, 1, "R7 clr+daz");
    op(0, 0, 1, 32'h9F80, 0, 0, 1, "R5 fz");
    op(0, 0, 1, 32'h8040, 0, 0, 1, "R5 unmask first");
    op(0, 0, 0, 0, 0, 0, 1, "R6 clear3");
    // R3 rounding and upper bits
    op(0, 0, 1, 32'h7F80, 0, 0, 0, "R3 rm3");
    op(0, 0, 1, 32'hFFFF_3F80, 0, 0, 0, "R3 upper ignored");
    op(0, 0, 1, 32'h5F80, 0, 0, 0, "R3 rm2");
    // R7 both units warn
    op(1, 16'h027F, 1, 32'h1F00, 0, 0, 1, "R7 both");
    op(1, 16'h007F, 1, 32'h1FC0, 0, 0, 1, "R7 both 2v3");
    op(0, 0, 0, 0, 0, 0, 1, "R6 clear4");
    // R8 condition codes
    op(0, 0, 0, 0, 1, 16'hFFFF, 0, "R8 all");
    op(0, 0, 0, 0, 1, 16'h4500, 0, "R8 c3c2c0");
    op(0, 0, 0, 0, 1, 16'hBBFF, 0, "R8 mixed");
    op(1, 16'h077F, 0, 0, 1, 16'h0000, 0, "R8 with fpu load");
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule